// File: doc/BRIEF.md
# Operation Time-Frame Monitor

This block measures how many clock cycles an operation takes. A start strobe opens a measurement window and an end strobe closes it. The block keeps the elapsed count of the last completed operation and compares it against a programmable lower and upper limit. When the duration is out of range, when an operation is restarted before it closes, or when an open operation runs past the upper limit because its end never came, the block sets a sticky flag. Any set flag drives a dedicated alert pin at once, without a scan access.

Software reaches the block only through a scan chain that is synchronous to the system clock. The chain holds a segment-select bit and a data register behind it. While the select bit is 0 the chain is one bit long and the data register is neither captured nor updated. While it is 1, a capture loads the flags and the last count into the data register. An update loads the limits, the enable and a write-one-to-clear mask for the flags.

Top module: `optime_monitor`

## Requirements
- R1: While enabled, a start strobe clears the elapsed counter and opens a measurement. While the enable is 0, start strobes are ignored and no measurement opens.
- R2: An end strobe during an open measurement closes it. It stores the distance in clock edges between the start edge and the end edge as the last count. The last count keeps its value until the next completed measurement.
- R3: The elapsed counter saturates at all ones (255 when CNT_W is 8) and does not wrap. A measurement longer than that reports all ones.
- R4: While a measurement is open, the overrun flag (bit 2) sets on the edge where the elapsed count first exceeds the upper limit. It does not set earlier.
- R5: A completed count below the lower limit sets the short flag (bit 0). A count above the upper limit sets the long flag (bit 1). Counts equal to either limit set neither flag.
- R6: A start strobe during an open measurement restarts it from zero and sets the restart flag (bit 3). When start and end arrive in the same cycle, the start wins and the end is ignored.
- R7: Flags stay set until an update writes 1 to their bit of the clear mask. Bits written 0 leave their flags unchanged.
- R8: `alert_o` is high whenever any flag is set. It rises right after the edge that sets a flag and falls right after the edge that clears the last one.
- R9: The segment-select bit resets to 0. The bit shifted into it is loaded on update. When it is 0, the chain from `tdi` to `tdo` is one bit long, a capture puts 0 on `tdo`, and an update leaves the limits and enable unchanged. When it is 1, the data register sits between `tdi` and the select bit. Bits shift toward `tdo`, so the first bit shifted lands in the select bit and the next ones fill the register LSB first.
- R10: Data register layout, with W = 2*CNT_W+5. Capture image: [CNT_W-1:0] is the last count, [CNT_W+3:CNT_W] are the flags, and the rest is 0. Update image: [CNT_W-1:0] is the lower limit, [2*CNT_W-1:CNT_W] is the upper limit, [2*CNT_W+3:2*CNT_W] is the clear mask, and [2*CNT_W+4] is the enable. Reset values: lower limit 0, upper limit all ones, enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also clocks the scan chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| som_i | input | 1 | Start-of-operation strobe |
| eom_i | input | 1 | End-of-operation strobe |
| alert_o | output | 1 | High while any sticky flag is set |
| scan_sel | input | 1 | The instruction in force selects this chain |
| capture_dr | input | 1 | Capture phase, one cycle |
| shift_dr | input | 1 | Shift phase, one bit per cycle |
| update_dr | input | 1 | Update phase, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The assertions assume that the scan controls are one-hot in any cycle and that strobes are single-cycle pulses synchronous to `clk`. The stimulus raises each scan phase alone for a whole cycle and drives strobes as one-cycle pulses on falling edges. The saturation and restart properties also assume the enable does not change in the middle of a measurement. The bench writes configuration only between measurements or while an overrun is pending, and that is the only case it relies on.

// File: rtl/optime_monitor.sv
module optime_monitor #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic som_i,
  input  logic eom_i,
  output logic alert_o,
  input  logic scan_sel,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo
);
  localparam int NF = 4;
  localparam int W  = 2*CNT_W + NF + 1;
  localparam logic [CNT_W-1:0] ONES = '1;

  logic             run;
  logic [CNT_W-1:0] cnt, inc, last, lo_lim, hi_lim;
  logic [NF-1:0]    flags, set, clr;
  logic             en, seg_q, seg_sr;
  logic [W-1:0]     dr_sr;
  logic             cap, sh, upd, start, done;

  assign inc   = (cnt == ONES) ? cnt : cnt + 1'b1;
  assign start = en & som_i;
  assign done  = run & eom_i & ~start;
  assign cap   = scan_sel & capture_dr;
  assign sh    = scan_sel & shift_dr;
  assign upd   = scan_sel & update_dr;
  assign clr   = (upd & seg_q) ? dr_sr[2*CNT_W +: NF] : '0;

  assign set[0] = done & (inc < lo_lim);
  assign set[1] = done & (inc > hi_lim);
  assign set[2] = run & ~start & ~eom_i & (inc > hi_lim);
  assign set[3] = start & run;

  assign alert_o = |flags;
  assign tdo     = seg_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      last  <= '0;
      flags <= '0;
    end else begin
      if (!en)        run <= 1'b0;
      else if (start) run <= 1'b1;
      else if (done)  run <= 1'b0;
      if (start)    cnt <= '0;
      else if (run) cnt <= inc;
      if (done) last <= inc;
      flags <= (flags & ~clr) | set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= 1'b0;
      seg_sr <= 1'b0;
      dr_sr  <= '0;
      lo_lim <= '0;
      hi_lim <= '1;
      en     <= 1'b0;
    end else begin
      if (cap) begin
        seg_sr <= seg_q;
        if (seg_q) dr_sr <= {{(W-CNT_W-NF){1'b0}}, flags, last};
      end else if (sh) begin
        seg_sr <= seg_q ? dr_sr[0] : tdi;
        if (seg_q) dr_sr <= {tdi, dr_sr[W-1:1]};
      end
      if (upd) begin
        seg_q <= seg_sr;
        if (seg_q) begin
          lo_lim <= dr_sr[CNT_W-1:0];
          hi_lim <= dr_sr[2*CNT_W-1:CNT_W];
          en     <= dr_sr[W-1];
        end
      end
    end
  end

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && cnt == '0));

  assert_end_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run);

  assert_last_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(last));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && en && cnt == ONES) |=> cnt == ONES);

  assert_overrun_only_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(run));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && seg_q) |=> (($past(flags) & ~flags) == '0));

  assert_bypass_keeps_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !seg_q) |=> ($stable(lo_lim) && $stable(hi_lim) && $stable(en)));
endmodule

// File: tb/tb_optime_monitor.sv
module tb_optime_monitor;
  localparam int CNT_W = 8;
  localparam int W = 2*CNT_W + 5;

  logic clk = 0, rst_n = 0, som = 0, eom = 0;
  logic scan_sel = 1, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic alert, tdo;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] rd_obs;
  event rd_ev;

  logic [CNT_W-1:0] c_lo = 5, c_hi = 20;
  logic c_en = 1;

  always #10 clk = ~clk;

  optime_monitor #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .som_i(som), .eom_i(eom), .alert_o(alert),
    .scan_sel(scan_sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic seg_only(input logic b, output logic cap_bit);
    @(negedge clk) capture_dr = 1;
    @(negedge clk) capture_dr = 0; cap_bit = tdo; shift_dr = 1; tdi = b;
    @(negedge clk) shift_dr = 0; update_dr = 1;
    @(negedge clk) update_dr = 0;
  endtask

  task automatic access(input logic seg_in, input logic [3:0] clr, output logic [W-1:0] rd);
    logic [W-1:0] wr;
    wr = {c_en, clr, c_hi, c_lo};
    @(negedge clk) capture_dr = 1;
    @(negedge clk) capture_dr = 0; shift_dr = 1;
    for (int i = 0; i <= W; i++) begin
      if (i > 0) rd[i-1] = tdo;
      tdi = (i == 0) ? seg_in : wr[i-1];
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk) update_dr = 0;
  endtask

  task automatic expect_rd(input string req, input logic [3:0] fl, input logic [CNT_W-1:0] cnt,
                           input logic [3:0] clr);
    logic [W-1:0] r;
    exp_q.push_back({{(CNT_W+1){1'b0}}, fl, cnt});
    tag_q.push_back(req);
    access(1'b1, clr, r);
    rd_obs = r;
    -> rd_ev;
    @(negedge clk);
  endtask

  task automatic meas(input int k);
    @(negedge clk) som = 1;
    @(negedge clk) som = 0;
    repeat (k-1) @(negedge clk);
    eom = 1;
    @(negedge clk) eom = 0;
  endtask

  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", rd_obs);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_obs, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset alert", alert, 0);
    seg_only(1'b0, b);
    check("R9 closed capture", b, 0);
    seg_only(1'b1, b);
    meas(3);
    check("R1 disabled no alert", alert, 0);
    expect_rd("R1 disabled start ignored", 4'h0, 0, 4'h0);
    meas(10);
    expect_rd("R2 count 10", 4'h0, 10, 4'h0);
    meas(3);
    check("R8 alert on short", alert, 1);
    expect_rd("R5 short flag", 4'h1, 3, 4'h0);
    expect_rd("R7 sticky before clear", 4'h1, 3, 4'h1);
    check("R8 alert after clear", alert, 0);
    expect_rd("R7 cleared", 4'h0, 3, 4'h0);
    meas(5);
    expect_rd("R5 equal lower", 4'h0, 5, 4'h0);
    meas(20);
    expect_rd("R5 equal upper", 4'h0, 20, 4'h0);
    meas(21);
    expect_rd("R5 long flag", 4'h2, 21, 4'h2);
    expect_rd("R7 long cleared", 4'h0, 21, 4'h0);
    @(negedge clk) som = 1;
    @(negedge clk) som = 0;
    repeat (20) @(negedge clk);
    check("R4 no overrun at limit", alert, 0);
    @(negedge clk);
    check("R4 overrun past limit", alert, 1);
    meas(8);
    expect_rd("R6 restart and R4 overrun", 4'hC, 8, 4'hC);
    @(negedge clk) begin som = 1; eom = 1; end
    @(negedge clk) begin som = 0; eom = 0; end
    repeat (5) @(negedge clk);
    eom = 1;
    @(negedge clk) eom = 0;
    expect_rd("R6 start wins over end", 4'h0, 6, 4'h0);
    c_lo = 0; c_hi = 8'hFF;
    expect_rd("R10 config write", 4'h0, 6, 4'h0);
    meas(300);
    expect_rd("R3 saturation", 4'h0, 8'hFF, 4'h0);
    c_lo = 5; c_hi = 20;
    begin
      logic [W-1:0] r;
      access(1'b0, 4'h0, r);
    end
    @(negedge clk) capture_dr = 1;
    @(negedge clk) capture_dr = 0; shift_dr = 1; tdi = 1;
    @(negedge clk) tdi = 0;
    check("R9 one-bit path", tdo, 1);
    @(negedge clk) shift_dr = 0; tdi = 0;
    check("R9 one-bit path second", tdo, 0);
    @(negedge clk) update_dr = 1;
    @(negedge clk) update_dr = 0;
    meas(3);
    check("R9 config kept while closed", alert, 1);
    seg_only(1'b1, b);
    check("R9 closed capture shows 0", b, 0);
    expect_rd("R9 reopened readout", 4'h1, 3, 4'h1);
    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule